// File: doc/BRIEF.md
# BCD Clock-Calendar Register Bank

This block keeps wall-clock time and date as a bank of separate 4-bit BCD digits. The digits are tenths of a second, seconds, minutes, hours (24-hour), day of week, day of month and month. A host reaches each digit through a 4-bit address, a write strobe with a 4-bit write data port, and a read strobe that returns one digit on a registered 4-bit read port. A one-hot leap-year phase register, which the host can write but not read, sets the length of February. It rotates at each year end.

A separate timebase supplies a single-cycle increment pulse every tenth of a second. The pulse counts only while the run latch is set. While the latch is clear, the three seconds digits are held at zero, so the host can load the time and start the clock at a precise moment. Every counted pulse sets a data-changed flag. The next read after a pulse returns 1111 in place of the digit and clears the flag, which tells software that its snapshot may be torn.

Top module: `bcd_clock_regs`

## Requirements
- R1: The address map of the digits is: 1 tenths, 2 seconds units, 3 seconds tens, 4 minutes units, 5 minutes tens, 6 hours units, 7 hours tens, 8 day units, 9 day tens, 10 day of week, 11 month units, 12 month tens. Reads of 0, 13, 14 and 15 return 0000. Writes to addresses 1 to 3 have no effect. After reset, the time reads 00:00:00.0, the date reads day 01, month 01, day of week 1, and the clock is stopped.
- R2: Each counted pulse advances tenths 0 to 9. Its wrap carries into seconds, which count 00 to 59 and whose wrap carries into minutes.
- R3: Minutes count 00 to 59 and hours count 00 to 23. The pulse after 23:59:59.9 gives 00:00:00.0 and advances the date by one day.
- R4: Day of week advances once per day from 1 to 7 and then back to 1.
- R5: Day of month rolls over to 01 after 31 in months 1, 3, 5, 7, 8, 10 and 12, and after 30 in months 4, 6, 9 and 11. At that point the month advances.
- R6: In February the day rolls over after 29 when the leap register holds 1000 (leap year). It rolls over after 28 for the other phases 0100, 0010 and 0001.
- R7: The pulse that ends December 31 23:59:59.9 sets month 01, day 01, and rotates the leap register one place right (1000 to 0100 to 0010 to 0001 to 1000). Address 13 loads that register directly.
- R8: Unused high bits are dropped on write and read as 0. Month tens keeps bit 0, day tens and hours tens keep bits 1:0, minutes tens keeps bits 2:0, and day of week keeps bits 2:0.
- R9: Writing address 14 with bit 0 = 0 stops the clock: increment pulses are ignored and the three seconds digits are held at 0. Writing bit 0 = 1 starts counting, and the first pulse gives tenths 1.
- R10: A counted pulse sets a data-changed flag. A read while the flag is set returns 1111. Every read clears the flag, and pulses ignored while stopped do not set it.
- R11: When a write and a counted pulse fall in the same cycle, the addressed digit takes the written value. The other digits still advance.
- R12: Bit 3 written to address 0 sets the test-mode output `test_o`. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Tenth-second increment pulse from the timebase |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe; `rdata_o` is valid the cycle after |
| addr_i | input | 4 | Digit address |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Registered read data |
| test_o | output | 1 | Test-mode control bit |

## Verification
The bench targets the rollover corners: 23:59:59.9 into a new day, every February phase of the leap register, and 30-day and 31-day months. It also runs the December 31 year end, and then a later February exposes whether the leap register rotated. A design with the wrong rotation direction, or with a stuck leap register, shows the wrong day count on that February. The bench checks that a read right after a pulse returns 1111 and that the following read returns the true digit: a sticky flag would repeat 1111, and a missing flag would expose the digit. Further checks cover pulses while stopped, which must neither count nor raise the flag, and a write colliding with a pulse, where the written value must win.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

  localparam int ADDR_W = 4;
  localparam int DIG_W  = 4;
  localparam int N_ADDR = 1 << ADDR_W;

  typedef logic [DIG_W-1:0]  digit_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_TEST   = 4'd0;
  localparam addr_t A_TENTHS = 4'd1;
  localparam addr_t A_SEC_U  = 4'd2;
  localparam addr_t A_SEC_T  = 4'd3;
  localparam addr_t A_MIN_U  = 4'd4;
  localparam addr_t A_MIN_T  = 4'd5;
  localparam addr_t A_HR_U   = 4'd6;
  localparam addr_t A_HR_T   = 4'd7;
  localparam addr_t A_DAY_U  = 4'd8;
  localparam addr_t A_DAY_T  = 4'd9;
  localparam addr_t A_DOW    = 4'd10;
  localparam addr_t A_MON_U  = 4'd11;
  localparam addr_t A_MON_T  = 4'd12;
  localparam addr_t A_LEAP   = 4'd13;
  localparam addr_t A_RUN    = 4'd14;

  localparam digit_t BCD_MAX  = 4'd9;
  localparam digit_t GUARD_RD = 4'hF;

  // Last day of the month as two BCD digits {tens, units}
  function automatic logic [7:0] last_day_bcd(input digit_t mon_t,
                                              input digit_t mon_u,
                                              input logic   leap_now);
    logic [4:0] m;
    m = (mon_t != 4'd0) ? (5'd10 + {1'b0, mon_u}) : {1'b0, mon_u};
    case (m)
      5'd2:                    return leap_now ? 8'h29 : 8'h28;
      5'd4, 5'd6, 5'd9, 5'd11: return 8'h30;
      default:                 return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_pair_ctr.sv
module bcd_pair_ctr
  import bcd_clock_pkg::*;
#(
  parameter int     TENS_W    = 3,
  parameter digit_t MIN_UNITS = 4'd0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_i,
  input  logic   inc_i,
  input  digit_t max_t_i,
  input  digit_t max_u_i,
  input  logic   wr_u_i,
  input  logic   wr_t_i,
  input  digit_t wdata_i,
  output digit_t units_o,
  output digit_t tens_o,
  output logic   wrap_o
);
  localparam digit_t TENS_MASK = digit_t'((1 << TENS_W) - 1);

  digit_t units_q, tens_q, units_d, tens_d;
  logic   at_max, en;

  always_comb begin
    at_max  = (tens_q == max_t_i) && (units_q == max_u_i);
    units_d = units_q;
    tens_d  = tens_q;
    if (inc_i) begin
      if (at_max) begin
        units_d = MIN_UNITS;
        tens_d  = '0;
      end else if (units_q >= BCD_MAX) begin
        units_d = '0;
        tens_d  = (tens_q + 4'd1) & TENS_MASK;
      end else begin
        units_d = units_q + 4'd1;
      end
    end
    if (clr_i) begin
      units_d = MIN_UNITS;
      tens_d  = '0;
    end
    if (wr_u_i) units_d = wdata_i;
    if (wr_t_i) tens_d  = wdata_i & TENS_MASK;
  end

  assign en     = inc_i | clr_i | wr_u_i | wr_t_i;
  assign wrap_o = inc_i & at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units_q <= MIN_UNITS;
      tens_q  <= '0;
    end else if (en) begin
      units_q <= units_d;
      tens_q  <= tens_d;
    end
  end

  assign units_o = units_q;
  assign tens_o  = tens_q;

  AST_PAIR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && at_max && !wr_u_i && !wr_t_i && !clr_i) |=> (tens_q == 4'd0 && units_q == MIN_UNITS)); // R3
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i && !wr_u_i && !wr_t_i) |=> ($stable(units_q) && $stable(tens_q))); // R1
  AST_TENS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t_i |=> ((tens_q & ~TENS_MASK) == 4'd0)); // R8

endmodule

// File: rtl/bcd_time_chain.sv
module bcd_time_chain
  import bcd_clock_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   inc_i,
  input  logic   run_i,
  input  logic   wr_i,
  input  addr_t  addr_i,
  input  digit_t wdata_i,
  output digit_t tenths_o,
  output digit_t sec_u_o,
  output digit_t sec_t_o,
  output digit_t min_u_o,
  output digit_t min_t_o,
  output digit_t hr_u_o,
  output digit_t hr_t_o,
  output logic   day_wrap_o
);
  digit_t tenths_q, tenths_d;
  logic   tenths_en, tenths_wrap, sec_wrap, min_wrap;

  always_comb begin
    tenths_d  = tenths_q;
    tenths_en = 1'b0;
    if (!run_i) begin
      tenths_d  = '0;
      tenths_en = 1'b1;
    end else if (inc_i) begin
      tenths_d  = (tenths_q >= BCD_MAX) ? 4'd0 : tenths_q + 4'd1;
      tenths_en = 1'b1;
    end
  end

  assign tenths_wrap = inc_i & run_i & (tenths_q >= BCD_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tenths_q <= '0;
    else if (tenths_en) tenths_q <= tenths_d;
  end

  bcd_pair_ctr #(.TENS_W(3), .MIN_UNITS(4'd0)) u_sec (
    .clk, .rst_n, .clr_i(!run_i), .inc_i(tenths_wrap),
    .max_t_i(4'd5), .max_u_i(4'd9), .wr_u_i(1'b0), .wr_t_i(1'b0),
    .wdata_i, .units_o(sec_u_o), .tens_o(sec_t_o), .wrap_o(sec_wrap)
  );

  bcd_pair_ctr #(.TENS_W(3), .MIN_UNITS(4'd0)) u_min (
    .clk, .rst_n, .clr_i(1'b0), .inc_i(sec_wrap),
    .max_t_i(4'd5), .max_u_i(4'd9),
    .wr_u_i(wr_i && addr_i == A_MIN_U), .wr_t_i(wr_i && addr_i == A_MIN_T),
    .wdata_i, .units_o(min_u_o), .tens_o(min_t_o), .wrap_o(min_wrap)
  );

  bcd_pair_ctr #(.TENS_W(2), .MIN_UNITS(4'd0)) u_hr (
    .clk, .rst_n, .clr_i(1'b0), .inc_i(min_wrap),
    .max_t_i(4'd2), .max_u_i(4'd3),
    .wr_u_i(wr_i && addr_i == A_HR_U), .wr_t_i(wr_i && addr_i == A_HR_T),
    .wdata_i, .units_o(hr_u_o), .tens_o(hr_t_o), .wrap_o(day_wrap_o)
  );

  assign tenths_o = tenths_q;

  AST_SECONDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i) |=> (tenths_q == 4'd0 && sec_u_o == 4'd0 && sec_t_o == 4'd0)); // R9
  AST_TENTHS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    tenths_q <= BCD_MAX); // R2

endmodule

// File: rtl/bcd_date_chain.sv
module bcd_date_chain
  import bcd_clock_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   day_inc_i,
  input  logic   wr_i,
  input  addr_t  addr_i,
  input  digit_t wdata_i,
  output digit_t dow_o,
  output digit_t day_u_o,
  output digit_t day_t_o,
  output digit_t mon_u_o,
  output digit_t mon_t_o
);
  logic [2:0] dow_q, dow_d;
  digit_t     leap_q, leap_d;
  logic       dow_en, leap_en, wr_dow, wr_leap, mon_wrap, year_wrap;
  logic [7:0] last_day;

  assign wr_dow  = wr_i && addr_i == A_DOW;
  assign wr_leap = wr_i && addr_i == A_LEAP;
  assign last_day = last_day_bcd(mon_t_o, mon_u_o, leap_q[3]);

  bcd_pair_ctr #(.TENS_W(2), .MIN_UNITS(4'd1)) u_day (
    .clk, .rst_n, .clr_i(1'b0), .inc_i(day_inc_i),
    .max_t_i(last_day[7:4]), .max_u_i(last_day[3:0]),
    .wr_u_i(wr_i && addr_i == A_DAY_U), .wr_t_i(wr_i && addr_i == A_DAY_T),
    .wdata_i, .units_o(day_u_o), .tens_o(day_t_o), .wrap_o(mon_wrap)
  );

  bcd_pair_ctr #(.TENS_W(1), .MIN_UNITS(4'd1)) u_mon (
    .clk, .rst_n, .clr_i(1'b0), .inc_i(mon_wrap),
    .max_t_i(4'd1), .max_u_i(4'd2),
    .wr_u_i(wr_i && addr_i == A_MON_U), .wr_t_i(wr_i && addr_i == A_MON_T),
    .wdata_i, .units_o(mon_u_o), .tens_o(mon_t_o), .wrap_o(year_wrap)
  );

  always_comb begin
    dow_d  = dow_q;
    dow_en = 1'b0;
    if (wr_dow) begin
      dow_d  = wdata_i[2:0];
      dow_en = 1'b1;
    end else if (day_inc_i) begin
      dow_d  = (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      dow_en = 1'b1;
    end
  end

  always_comb begin
    leap_d  = leap_q;
    leap_en = 1'b0;
    if (wr_leap) begin
      leap_d  = wdata_i;
      leap_en = 1'b1;
    end else if (year_wrap) begin
      leap_d  = {leap_q[0], leap_q[3:1]};
      leap_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q  <= 3'd1;
      leap_q <= 4'b1000;
    end else begin
      if (dow_en)  dow_q  <= dow_d;
      if (leap_en) leap_q <= leap_d;
    end
  end

  assign dow_o = {1'b0, dow_q};

  AST_LEAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_leap && !year_wrap) |=> $stable(leap_q)); // R7
  AST_LEAP_ONE_HOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_leap && $onehot0(leap_q) && $countones(leap_q) == 1) |=> ($countones(leap_q) == 1)); // R7
  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc_i && !wr_dow && dow_q != 3'd0) |=> (dow_q != 3'd0)); // R4
  AST_YEAR_START: assert property (@(posedge clk) disable iff (!rst_n)
    (year_wrap && !wr_i) |=> (mon_u_o == 4'd1 && mon_t_o == 4'd0 && day_u_o == 4'd1 && day_t_o == 4'd0)); // R7

endmodule

// File: rtl/bcd_read_port.sv
module bcd_read_port
  import bcd_clock_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc_i,
  input  logic                    rd_i,
  input  addr_t                   addr_i,
  input  logic [N_ADDR-1:0][DIG_W-1:0] dig_i,
  output digit_t                  rdata_o
);
  logic   flag_q, flag_d;
  digit_t rdata_q, rdata_d;

  always_comb begin
    flag_d  = flag_q;
    rdata_d = rdata_q;
    if (rd_i) begin
      rdata_d = flag_q ? GUARD_RD : dig_i[addr_i];
      flag_d  = 1'b0;
    end
    if (inc_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (rd_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> flag_q); // R10
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !inc_i) |=> !flag_q); // R10
  AST_READ_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && flag_q) |=> (rdata_o == GUARD_RD)); // R10

endmodule

// File: rtl/bcd_clock_regs.sv
module bcd_clock_regs
  import bcd_clock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [3:0] addr_i,
  input  logic [3:0] wdata_i,
  output logic [3:0] rdata_o,
  output logic       test_o
);
  logic   rst_meta, rst_sync_n;
  logic   run_q, run_d, test_q, test_d, inc, day_wrap;
  digit_t tenths, sec_u, sec_t, min_u, min_t, hr_u, hr_t;
  digit_t dow, day_u, day_t, mon_u, mon_t;
  logic [N_ADDR-1:0][DIG_W-1:0] dig;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    run_d  = run_q;
    test_d = test_q;
    if (wr_i && addr_i == A_RUN)  run_d  = wdata_i[0];
    if (wr_i && addr_i == A_TEST) test_d = wdata_i[3];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q  <= 1'b0;
      test_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      test_q <= test_d;
    end
  end

  assign inc = tick_i & run_q;

  bcd_time_chain u_time (
    .clk, .rst_n(rst_sync_n), .inc_i(inc), .run_i(run_q), .wr_i, .addr_i, .wdata_i,
    .tenths_o(tenths), .sec_u_o(sec_u), .sec_t_o(sec_t), .min_u_o(min_u), .min_t_o(min_t),
    .hr_u_o(hr_u), .hr_t_o(hr_t), .day_wrap_o(day_wrap)
  );

  bcd_date_chain u_date (
    .clk, .rst_n(rst_sync_n), .day_inc_i(day_wrap), .wr_i, .addr_i, .wdata_i,
    .dow_o(dow), .day_u_o(day_u), .day_t_o(day_t), .mon_u_o(mon_u), .mon_t_o(mon_t)
  );

  always_comb begin
    dig           = '0;
    dig[A_TENTHS] = tenths;
    dig[A_SEC_U]  = sec_u;
    dig[A_SEC_T]  = sec_t;
    dig[A_MIN_U]  = min_u;
    dig[A_MIN_T]  = min_t;
    dig[A_HR_U]   = hr_u;
    dig[A_HR_T]   = hr_t;
    dig[A_DAY_U]  = day_u;
    dig[A_DAY_T]  = day_t;
    dig[A_DOW]    = dow;
    dig[A_MON_U]  = mon_u;
    dig[A_MON_T]  = mon_t;
  end

  bcd_read_port u_rd (
    .clk, .rst_n(rst_sync_n), .inc_i(inc), .rd_i, .addr_i, .dig_i(dig), .rdata_o
  );

  assign test_o = test_q;

  AST_RUN_LATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_i && addr_i == A_RUN) |=> (run_q == $past(wdata_i[0]))); // R9
  AST_TEST_LATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_i && addr_i == A_TEST) |=> (test_o == $past(wdata_i[3]))); // R12

endmodule

// File: tb/bcd_clock_regs_tb.sv
module bcd_clock_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n, tick_i, wr_i, rd_i;
  logic [3:0] addr_i, wdata_i, rdata_o;
  logic       test_o;

  int checks = 0;
  int errors = 0;
  logic flag_m = 1'b0;
  logic run_m  = 1'b0;
  logic rd_seen = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  bcd_clock_regs u_dut (
    .clk, .rst_n, .tick_i, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o, .test_o
  );

  // Monitor: pops one expectation per completed read
  always @(posedge clk) rd_seen <= rd_i;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata_o !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata_o, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    if (a == 4'd14) run_m = d[0];
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] v, input string t);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a;
    exp_q.push_back(flag_m ? 4'hF : v);
    tag_q.push_back(t);
    flag_m = 1'b0;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    if (run_m) flag_m = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic tick_wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    tick_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    if (run_m) flag_m = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic chk_test(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (test_o !== e) begin
      errors++;
      $display("FAIL %s: test_o actual %b expected %b", t, test_o, e);
    end
  endtask

  // Stop, load 23:59 and the given date, restart; 600 pulses cross midnight
  task automatic load_eod(input logic [3:0] dt, du, mt, mu, w);
    wr(4'd14, 4'd0);
    wr(4'd4, 4'd9); wr(4'd5, 4'd5); wr(4'd6, 4'd3); wr(4'd7, 4'd2);
    wr(4'd8, du); wr(4'd9, dt); wr(4'd11, mu); wr(4'd12, mt); wr(4'd10, w);
    wr(4'd14, 4'd1);
    tick(600);
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and address map
    rd(4'd1, 4'd0, "R1"); rd(4'd8, 4'd1, "R1"); rd(4'd10, 4'd1, "R1");
    rd(4'd11, 4'd1, "R1"); rd(4'd12, 4'd0, "R1"); rd(4'd13, 4'd0, "R1");
    chk_test(1'b0, "R12");

    // R12: test bit
    wr(4'd0, 4'h8); chk_test(1'b1, "R12");
    wr(4'd0, 4'h7); chk_test(1'b0, "R12");

    // R9: stopped clock ignores pulses, no flag
    tick(5);
    rd(4'd1, 4'd0, "R9");

    // R2/R10: start and count
    wr(4'd14, 4'd1);
    tick(3);
    rd(4'd1, 4'd3, "R10"); rd(4'd1, 4'd3, "R2"); rd(4'd1, 4'd3, "R10");
    tick(9);
    rd(4'd2, 4'd1, "R10"); rd(4'd2, 4'd1, "R2"); rd(4'd1, 4'd2, "R2");
    wr(4'd14, 4'd0);
    rd(4'd1, 4'd0, "R9"); rd(4'd2, 4'd0, "R9");

    // R1: read-only and write-only addresses
    wr(4'd2, 4'd5); rd(4'd2, 4'd0, "R1");
    wr(4'd13, 4'hF); rd(4'd13, 4'd0, "R1");

    // R8: unused bits
    wr(4'd12, 4'hF); rd(4'd12, 4'd1, "R8");
    wr(4'd10, 4'hF); rd(4'd10, 4'd7, "R8");
    wr(4'd7, 4'hF);  rd(4'd7, 4'd3, "R8");
    wr(4'd9, 4'hF);  rd(4'd9, 4'd3, "R8");
    wr(4'd5, 4'hF);  rd(4'd5, 4'd7, "R8");

    // R3/R4/R7: year end from leap-3 phase
    wr(4'd13, 4'b0001);
    load_eod(4'd3, 4'd1, 4'd1, 4'd2, 4'd7);
    rd(4'd1, 4'd0, "R10"); rd(4'd1, 4'd0, "R3"); rd(4'd2, 4'd0, "R3");
    rd(4'd3, 4'd0, "R3"); rd(4'd4, 4'd0, "R3"); rd(4'd5, 4'd0, "R3");
    rd(4'd6, 4'd0, "R3"); rd(4'd7, 4'd0, "R3"); rd(4'd10, 4'd1, "R4");
    rd(4'd8, 4'd1, "R7"); rd(4'd9, 4'd0, "R7"); rd(4'd11, 4'd1, "R7"); rd(4'd12, 4'd0, "R7");

    // R6/R7: leap phase is now 1000, Feb 28 -> 29 -> Mar 1
    load_eod(4'd2, 4'd8, 4'd0, 4'd2, 4'd3);
    rd(4'd8, 4'd9, "R10"); rd(4'd8, 4'd9, "R6"); rd(4'd9, 4'd2, "R6");
    rd(4'd11, 4'd2, "R6"); rd(4'd10, 4'd4, "R4");
    load_eod(4'd2, 4'd9, 4'd0, 4'd2, 4'd4);
    rd(4'd8, 4'd1, "R10"); rd(4'd8, 4'd1, "R6"); rd(4'd9, 4'd0, "R6"); rd(4'd11, 4'd3, "R6");

    // R6: non-leap phases
    for (int k = 0; k < 3; k++) begin
      wr(4'd13, 4'b0100 >> k);
      load_eod(4'd2, 4'd8, 4'd0, 4'd2, 4'd1);
      rd(4'd8, 4'd1, "R10"); rd(4'd8, 4'd1, "R6"); rd(4'd9, 4'd0, "R6"); rd(4'd11, 4'd3, "R6");
    end

    // R5: month lengths
    load_eod(4'd3, 4'd0, 4'd0, 4'd4, 4'd1);
    rd(4'd8, 4'd1, "R10"); rd(4'd8, 4'd1, "R5"); rd(4'd11, 4'd5, "R5");
    load_eod(4'd3, 4'd0, 4'd0, 4'd3, 4'd1);
    rd(4'd8, 4'd1, "R10"); rd(4'd8, 4'd1, "R5"); rd(4'd9, 4'd3, "R5"); rd(4'd11, 4'd3, "R5");
    load_eod(4'd3, 4'd1, 4'd0, 4'd1, 4'd1);
    rd(4'd8, 4'd1, "R10"); rd(4'd8, 4'd1, "R5"); rd(4'd11, 4'd2, "R5");
    load_eod(4'd3, 4'd0, 4'd1, 4'd1, 4'd1);
    rd(4'd8, 4'd1, "R10"); rd(4'd8, 4'd1, "R5"); rd(4'd11, 4'd2, "R5"); rd(4'd12, 4'd1, "R5");

    // R7: year end from leap phase 1000 -> 0100, next February has 28 days
    wr(4'd13, 4'b1000);
    load_eod(4'd3, 4'd1, 4'd1, 4'd2, 4'd1);
    rd(4'd11, 4'd1, "R10"); rd(4'd11, 4'd1, "R7");
    load_eod(4'd2, 4'd8, 4'd0, 4'd2, 4'd1);
    rd(4'd8, 4'd1, "R10"); rd(4'd8, 4'd1, "R7"); rd(4'd11, 4'd3, "R7");

    // R11: write and pulse in one cycle
    wr(4'd14, 4'd0); wr(4'd4, 4'd2); wr(4'd14, 4'd1);
    tick_wr(4'd4, 4'd7);
    rd(4'd1, 4'd1, "R10"); rd(4'd1, 4'd1, "R11"); rd(4'd4, 4'd7, "R11");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule